// File: doc/BRIEF.md
# Mode-Aware Eight-Pin GPIO Port

This block is an eight-pin general-purpose I/O port driven from a simple synchronous register bus. Software sets which pins drive through a direction register and writes their output values into a data latch. It selects weak pull-ups for input pins and reads back the live state of the port. Each register sits at a fixed 16-bit address. Reads are combinational in the cycle the bus selects them. Writes take effect at the next rising clock edge.

A 3-bit operating-mode input decides who owns the pins. In modes 3 and 7 the port is GPIO and the direction register governs every pin. In modes 1, 2, 4, 5 and 6 the pins belong to the external data bus. Every GPIO output enable and pull-up is then off, the stored direction is ignored, and a flag reports the hand-over. Mode 0 is treated as reserved: the port drives nothing and raises no flag.

The four reset and standby inputs act differently. Power-on reset and hardware standby wipe all state. A manual reset clears the data latch and pull-up selection but keeps the direction register. Software standby freezes every register.

Top module: `gpio_mode_port`

## Requirements
- R1: The data latch sits at 0xFF6C and the pull-up register at 0xFF73. Both are 8 bits, and a write to either is read back unchanged on the next read of the same address. The direction register is at 0xFEBC and the pin-state register at 0xFF5C. A read of any other address, or with no read pending, returns 0x00.
- R2: A read of the direction register address (0xFEBC) always returns 0xFF, whatever is stored.
- R3: Power-on reset, or hardware standby at a clock edge, sets the direction register, data latch and pull-up register all to 0x00. No write lands in that cycle.
- R4: A manual reset keeps the direction register and clears the data latch and pull-up register. Software standby keeps all three registers. No write lands while either is active.
- R5: In mode 3 or 7, bit i of pin_oe equals direction bit i (1 = output). pin_out bit i is the data latch bit when the pin is an output and 0 otherwise. ext_bus_owned is 0.
- R6: In modes 1, 2, 4, 5 and 6, ext_bus_owned is 1 and pin_oe, pin_out and pin_pu are all 0. In mode 0 all four outputs are 0. A stored direction value survives a stay in these modes and takes effect again on return to mode 3 or 7.
- R7: A read of the pin-state address returns, per bit, the data latch bit for output pins and the synchronized pin level for input pins. In non-GPIO modes every pin counts as an input.
- R8: pin_pu bit i is 1 only when pull-up bit i is 1, pin i is an input, and the mode is 3 or 7.
- R9: A change on pin_in shows up in the pin-state readback after exactly two rising clock edges. The synchronizer stages clear on power-on reset.
- R10: A write to the pin-state address changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_por | input | 1 | Power-on reset, synchronous, active high |
| rst_man | input | 1 | Manual reset, synchronous, active high |
| hw_stby | input | 1 | Hardware standby request |
| sw_stby | input | 1 | Software standby request |
| mode | input | 3 | Operating mode |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Register address, low 16 bits |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| pin_in | input | 8 | External pin levels, asynchronous |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output value |
| pin_pu | output | 8 | Per-pin pull-up enable |
| ext_bus_owned | output | 1 | Port handed to the external data bus |

## Verification
Directed sequences come first. They write the direction register with a mixed pattern of four outputs and four inputs, which separates the latch path from the synchronized-pin path in the readback and in the pull-up gating. A manual reset and a software standby arrive with a pending direction write, which shows whether each reset kind keeps or clears the direction. Each mode group is visited in turn, and a return to GPIO mode proves the stored direction survived. After that, constrained-random cycles mix mostly-GPIO modes with rare resets and standbys, random addresses and random pin levels. These cycles expose wrong priority among the reset inputs and off-by-one synchronizer latency.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int PORT_W = 8;
    localparam int ADDR_W = 16;
    localparam int MODE_W = 3;

    localparam logic [ADDR_W-1:0] ADR_DIR = 16'hFEBC;
    localparam logic [ADDR_W-1:0] ADR_LAT = 16'hFF6C;
    localparam logic [ADDR_W-1:0] ADR_PIN = 16'hFF5C;
    localparam logic [ADDR_W-1:0] ADR_PUP = 16'hFF73;

    // Fixed pattern returned for the unreadable direction register
    localparam logic [PORT_W-1:0] DIR_RD_FILL = '1;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_DIR,
        REG_LAT,
        REG_PIN,
        REG_PUP
    } reg_sel_e;

    typedef enum logic [1:0] {
        PM_OFF,
        PM_GPIO,
        PM_EXTBUS
    } port_mode_e;

    typedef struct packed {
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] lat;
        logic [PORT_W-1:0] pup;
    } port_regs_t;

    typedef struct packed {
        logic [PORT_W-1:0] oe;
        logic [PORT_W-1:0] out;
        logic [PORT_W-1:0] pu;
    } pin_drive_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e r;
        case (a)
            ADR_DIR: r = REG_DIR;
            ADR_LAT: r = REG_LAT;
            ADR_PIN: r = REG_PIN;
            ADR_PUP: r = REG_PUP;
            default: r = REG_NONE;
        endcase
        return r;
    endfunction

    function automatic port_mode_e classify_mode(input logic [MODE_W-1:0] m);
        port_mode_e r;
        case (m)
            3'd3, 3'd7:                   r = PM_GPIO;
            3'd1, 3'd2, 3'd4, 3'd5, 3'd6: r = PM_EXTBUS;
            default:                      r = PM_OFF;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
    import gpio_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_por,
    input  logic              rst_man,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic              wr_en,
    input  reg_sel_e          wr_sel,
    input  logic [PORT_W-1:0] wr_data,
    output port_regs_t        regs
);

    port_regs_t regs_q;
    logic       wr_ok;

    // Writes are blocked by any reset or standby condition
    assign wr_ok = wr_en && !rst_man && !hw_stby && !sw_stby;

    always_ff @(posedge clk) begin
        if (rst_por || hw_stby) begin
            regs_q <= '0;
        end else if (rst_man) begin
            regs_q.lat <= '0;
            regs_q.pup <= '0;
        end else if (wr_ok) begin
            case (wr_sel)
                REG_DIR: regs_q.dir <= wr_data;
                REG_LAT: regs_q.lat <= wr_data;
                REG_PUP: regs_q.pup <= wr_data;
                default: ;
            endcase
        end
    end

    assign regs = regs_q;

    // R3: hardware standby clears direction
    a_r3_hwstby_clears_dir: assert property (@(posedge clk) disable iff (rst_por)
        hw_stby |=> (regs_q.dir == '0));

    // R4: manual reset and software standby keep direction
    a_r4_dir_kept: assert property (@(posedge clk) disable iff (rst_por)
        (!hw_stby && (rst_man || sw_stby)) |=> $stable(regs_q.dir));

    // R10: pin-state writes touch nothing
    a_r10_pin_write_ignored: assert property (@(posedge clk) disable iff (rst_por)
        (wr_en && wr_sel == REG_PIN && !hw_stby && !rst_man) |=> $stable(regs_q));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_async,
    output logic [W-1:0] pin_sync
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= pin_async;
            stage2_q <= stage1_q;
        end
    end

    assign pin_sync = stage2_q;

    // Checker-only age counter, saturating at two edges after reset
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst) age_q <= 2'd0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end

    // R9: two-edge latency from pin to synchronized value
    a_r9_two_stage_latency: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd2) |-> (pin_sync == $past(pin_async, 2)));

endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
    import gpio_port_pkg::*;
(
    input  port_mode_e        pmode,
    input  port_regs_t        regs,
    input  logic [PORT_W-1:0] pin_sync,
    output pin_drive_t        drv,
    output logic [PORT_W-1:0] pin_view
);

    logic gpio_on;
    assign gpio_on = (pmode == PM_GPIO);

    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        logic is_out;
        assign is_out      = gpio_on && regs.dir[i];
        assign drv.oe[i]   = is_out;
        assign drv.out[i]  = is_out && regs.lat[i];
        assign drv.pu[i]   = gpio_on && !regs.dir[i] && regs.pup[i];
        assign pin_view[i] = is_out ? regs.lat[i] : pin_sync[i];
    end

endmodule

// File: rtl/gpio_mode_port.sv
module gpio_mode_port
    import gpio_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_por,
    input  logic              rst_man,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic [MODE_W-1:0] mode,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_oe,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_pu,
    output logic              ext_bus_owned
);

    reg_sel_e          sel;
    port_mode_e        pmode;
    port_regs_t        regs;
    pin_drive_t        drv;
    logic [PORT_W-1:0] pin_sync;
    logic [PORT_W-1:0] pin_view;

    assign sel   = decode_addr(bus_addr);
    assign pmode = classify_mode(mode);

    gpio_reg_bank u_regs (
        .clk     (clk),
        .rst_por (rst_por),
        .rst_man (rst_man),
        .hw_stby (hw_stby),
        .sw_stby (sw_stby),
        .wr_en   (bus_sel && bus_we),
        .wr_sel  (sel),
        .wr_data (bus_wdata),
        .regs    (regs)
    );

    gpio_in_sync #(.W(PORT_W)) u_sync (
        .clk       (clk),
        .rst       (rst_por),
        .pin_async (pin_in),
        .pin_sync  (pin_sync)
    );

    gpio_pin_ctrl u_ctrl (
        .pmode    (pmode),
        .regs     (regs),
        .pin_sync (pin_sync),
        .drv      (drv),
        .pin_view (pin_view)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            case (sel)
                REG_DIR: bus_rdata = DIR_RD_FILL;
                REG_LAT: bus_rdata = regs.lat;
                REG_PIN: bus_rdata = pin_view;
                REG_PUP: bus_rdata = regs.pup;
                default: bus_rdata = '0;
            endcase
        end
    end

    assign pin_oe        = drv.oe;
    assign pin_out       = drv.out;
    assign pin_pu        = drv.pu;
    assign ext_bus_owned = (pmode == PM_EXTBUS);

    // R2: direction address never reveals stored contents
    a_r2_dir_reads_ones: assert property (@(posedge clk) disable iff (rst_por)
        (bus_sel && !bus_we && bus_addr == ADR_DIR) |-> (bus_rdata == '1));

    // R6: bus-owned modes drive nothing from GPIO
    a_r6_extbus_quiet: assert property (@(posedge clk) disable iff (rst_por)
        ext_bus_owned |-> (pin_oe == '0 && pin_pu == '0 && pin_out == '0));

    // R8: never pull up a pin that is driving
    a_r8_pu_not_on_output: assert property (@(posedge clk) disable iff (rst_por)
        ((pin_pu & pin_oe) == '0));

    // R5: an undriven pin outputs 0
    a_r5_out_within_oe: assert property (@(posedge clk) disable iff (rst_por)
        ((pin_out & ~pin_oe) == '0));

endmodule

// File: tb/sim_gpio_mode_port.sv
module sim_gpio_mode_port;

    logic        clk = 1'b0;
    logic        rst_por = 1'b1, rst_man = 1'b0, hw_stby = 1'b0, sw_stby = 1'b0;
    logic [2:0]  mode = 3'd3;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [15:0] bus_addr = 16'h0;
    logic [7:0]  bus_wdata = 8'h0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pin_in = 8'h0;
    logic [7:0]  pin_oe, pin_out, pin_pu;
    logic        ext_bus_owned;

    always #2 clk = ~clk;

    gpio_mode_port u0 (
        .clk(clk), .rst_por(rst_por), .rst_man(rst_man), .hw_stby(hw_stby),
        .sw_stby(sw_stby), .mode(mode), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu),
        .ext_bus_owned(ext_bus_owned)
    );

    localparam logic [15:0] A_DIR = 16'hFEBC, A_LAT = 16'hFF6C,
                            A_PIN = 16'hFF5C, A_PUP = 16'hFF73;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] m_dir = 0, m_lat = 0, m_pup = 0, m_s1 = 0, m_s2 = 0;

    function automatic bit is_gpio(input logic [2:0] m);
        return (m == 3'd3 || m == 3'd7);
    endfunction

    function automatic bit is_ext(input logic [2:0] m);
        return (m == 3'd1 || m == 3'd2 || m == 3'd4 || m == 3'd5 || m == 3'd6);
    endfunction

    function automatic logic [7:0] exp_oe();
        return is_gpio(mode) ? m_dir : 8'h00;
    endfunction

    function automatic logic [7:0] exp_rd();
        logic [7:0] od;
        od = exp_oe();
        if (!(bus_sel && !bus_we)) return 8'h00;
        case (bus_addr)
            A_DIR:   return 8'hFF;
            A_LAT:   return m_lat;
            A_PUP:   return m_pup;
            A_PIN:   return (od & m_lat) | (~od & m_s2);
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk({tag, " pin_oe (R5)"}, pin_oe, exp_oe());
        chk({tag, " pin_out (R5)"}, pin_out, exp_oe() & m_lat);
        chk({tag, " pin_pu (R8)"}, pin_pu, is_gpio(mode) ? (m_pup & ~m_dir) : 8'h00);
        chk({tag, " ext_bus_owned (R6)"}, {7'b0, ext_bus_owned}, {7'b0, is_ext(mode)});
        chk({tag, " bus_rdata (R1/R7)"}, bus_rdata, exp_rd());
    endtask

    task automatic model_edge();
        logic [7:0] sel_lat;
        if (rst_por || hw_stby) begin
            m_dir = 0; m_lat = 0; m_pup = 0;
        end else if (rst_man) begin
            m_lat = 0; m_pup = 0;
        end else if (!sw_stby && bus_sel && bus_we) begin
            sel_lat = bus_wdata;
            if (bus_addr == A_DIR) m_dir = sel_lat;
            if (bus_addr == A_LAT) m_lat = sel_lat;
            if (bus_addr == A_PUP) m_pup = sel_lat;
        end
        if (rst_por) begin
            m_s1 = 0; m_s2 = 0;
        end else begin
            m_s2 = m_s1; m_s1 = pin_in;
        end
    endtask

    task automatic cycle(input string tag, input bit por, input bit man, input bit hw,
                         input bit sw, input bit sel, input bit we, input logic [15:0] a,
                         input logic [7:0] wd, input logic [2:0] md, input logic [7:0] pin);
        @(negedge clk);
        rst_por = por; rst_man = man; hw_stby = hw; sw_stby = sw;
        bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = wd;
        mode = md; pin_in = pin;
        @(posedge clk);
        model_edge();
        #1;
        compare_all(tag);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED1));
        // R3: power-on state
        cycle("R3 por", 1, 0, 0, 0, 0, 0, 0, 0, 3'd3, 8'h00);
        cycle("R3 por", 1, 0, 0, 0, 0, 0, 0, 0, 3'd3, 8'h00);
        cycle("R3 after por", 0, 0, 0, 0, 1, 0, A_LAT, 0, 3'd3, 8'h00);
        // R1: latch and pull-up writes and readbacks
        cycle("R1 lat write", 0, 0, 0, 0, 1, 1, A_LAT, 8'hA5, 3'd3, 8'h00);
        cycle("R1 lat read", 0, 0, 0, 0, 1, 0, A_LAT, 0, 3'd3, 8'h00);
        cycle("R5 dir write", 0, 0, 0, 0, 1, 1, A_DIR, 8'h0F, 3'd3, 8'h00);
        cycle("R2 dir reads ones", 0, 0, 0, 0, 1, 0, A_DIR, 0, 3'd3, 8'h00);
        cycle("R8 pup write", 0, 0, 0, 0, 1, 1, A_PUP, 8'hFF, 3'd3, 8'h00);
        cycle("R1 pup read", 0, 0, 0, 0, 1, 0, A_PUP, 0, 3'd3, 8'h00);
        // R9: pin change seen after exactly two edges, R7 mixed view
        cycle("R9 pin edge1", 0, 0, 0, 0, 1, 0, A_PIN, 0, 3'd3, 8'h3C);
        chk("R9 not yet visible after one edge", bus_rdata, 8'h05);
        cycle("R9 pin edge2", 0, 0, 0, 0, 1, 0, A_PIN, 0, 3'd3, 8'h3C);
        chk("R7 mixed pin view", bus_rdata, 8'h35);
        // R10: write to pin-state ignored, observed via readbacks
        cycle("R10 pin write", 0, 0, 0, 0, 1, 1, A_PIN, 8'h00, 3'd3, 8'h3C);
        cycle("R10 lat after", 0, 0, 0, 0, 1, 0, A_LAT, 0, 3'd3, 8'h3C);
        chk("R10 latch unchanged", bus_rdata, 8'hA5);
        // R4: manual reset keeps direction, clears latch/pull-ups
        cycle("R4 manual", 0, 1, 0, 0, 1, 1, A_DIR, 8'h00, 3'd7, 8'h3C);
        chk("R4 dir kept through manual reset", pin_oe, 8'h0F);
        chk("R4 pull-ups cleared by manual reset", pin_pu, 8'h00);
        cycle("R4 sw standby", 0, 0, 0, 1, 1, 1, A_DIR, 8'hF0, 3'd7, 8'h3C);
        chk("R4 write blocked in sw standby", pin_oe, 8'h0F);
        // R6: mode groups
        cycle("R6 extbus", 0, 0, 0, 0, 1, 0, A_PIN, 0, 3'd5, 8'h3C);
        chk("R6 flag in mode 5", {7'b0, ext_bus_owned}, 8'h01);
        cycle("R6 mode0", 0, 0, 0, 0, 0, 0, 0, 0, 3'd0, 8'h3C);
        cycle("R6 return gpio", 0, 0, 0, 0, 0, 0, 0, 0, 3'd3, 8'h3C);
        chk("R6 dir retained", pin_oe, 8'h0F);
        // R3: hardware standby clears
        cycle("R3 hw standby", 0, 0, 1, 0, 1, 1, A_LAT, 8'h77, 3'd3, 8'h3C);
        chk("R3 dir cleared by hw standby", pin_oe, 8'h00);
        cycle("R1 unmapped", 0, 0, 0, 0, 1, 0, 16'h1234, 0, 3'd3, 8'h3C);
        // Random phase
        for (int k = 0; k < 4000; k++) begin
            logic [2:0]  md;
            logic [15:0] a;
            logic [2:0]  pick;
            pick = 3'($urandom_range(0, 4));
            case (pick)
                3'd0: a = A_DIR;
                3'd1: a = A_LAT;
                3'd2: a = A_PIN;
                3'd3: a = A_PUP;
                default: a = 16'($urandom);
            endcase
            md = ($urandom_range(0, 3) != 0) ? (($urandom_range(0, 1) != 0) ? 3'd3 : 3'd7)
                                             : 3'($urandom);
            cycle("random R1 R5 R7 R8",
                  $urandom_range(0, 199) == 0, $urandom_range(0, 99) == 0,
                  $urandom_range(0, 99) == 0, $urandom_range(0, 49) == 0,
                  $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, a,
                  8'($urandom), md, 8'($urandom));
        end
        finish_run();
    end

endmodule